// File: doc/BRIEF.md
# Line Reservation Atomic Unit

This block gives a requester a load-linked / store-conditional style of atomic update on whole 128-byte lines. A fetch-and-reserve command reads a line from external memory and, when the read completes, records a reservation on that line. A later conditional write sends the line back only if that reservation is still standing. A plain write always goes out. The unit watches a stream of snooped writes made by other agents. When one of them lands anywhere inside the reserved line, the reservation is dropped and a one-cycle reservation-lost event is raised.

Every command that is accepted ends with one status pulse and a two-bit status code. The code stays readable on `stat_code` until the next command completes. The memory side carries only a request, a write enable, a line-aligned address and a completion strobe. Moving the line data, the cache arrays and the bus protocol belong to the neighbouring logic.

The control state machine has four states. IDLE is the only state that accepts commands. FETCH means a line read is in flight. WR_COND means a conditional write is in flight. WR_UNCOND means a plain write is in flight. The transitions are:
- IDLE→FETCH when a fetch-and-reserve is accepted.
- IDLE→WR_COND when a conditional write is accepted and passes the check.
- IDLE→IDLE when a conditional write fails; no memory access takes place.
- IDLE→WR_UNCOND when a plain write is accepted.
- FETCH→IDLE, WR_COND→IDLE and WR_UNCOND→IDLE when `mem_done` arrives.

Top module: `ra_atomic_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_ready` is 1, and `mem_req`, `evt_resv_lost`, `stat_valid` and `stat_code` are 0.
- R2: `cmd_op` uses these codes: 01 fetch-and-reserve, 10 conditional write, 11 plain write. A fetch drives `mem_req`=1, `mem_we`=0 and `mem_addr` set to the command address with bits 6:0 cleared. One cycle after the cycle in which `mem_done` is seen, `stat_valid` pulses with `stat_code`=2.
- R3: Only one reservation exists at a time. An accepted fetch-and-reserve drops any earlier reservation, so a conditional write to the earlier line fails.
- R4: A conditional write whose line matches a valid reservation drives `mem_req`=1 and `mem_we`=1 with the line address. One cycle after `mem_done`, it reports `stat_code`=1.
- R5: A conditional write with no reservation, or to another line, or accepted in the same cycle as a killing snoop, makes no memory request. It reports `stat_valid`=1 with `stat_code`=0 in the cycle after acceptance.
- R6: A conditional write uses up the reservation whether it succeeds or fails, so a second one fails. It never raises `evt_resv_lost` by itself.
- R7: A plain write always performs the write and reports `stat_code`=3. It leaves the reservation untouched.
- R8: A snooped write (`snp_valid`=1, `snp_self`=0) that falls in the reserved line at 128-byte granularity clears the reservation. It pulses `evt_resv_lost` in the cycle after the snoop. A snoop to the neighbouring line does nothing.
- R9: A snoop flagged `snp_self`=1 never clears the reservation. A snoop that arrives while no reservation is held raises no event.
- R10: If a killing snoop to the fetched line arrives between acceptance and completion of a fetch-and-reserve (both ends included), no reservation is set. `evt_resv_lost` pulses together with the completion status.
- R11: `cmd_ready` is 0 while a memory access is in flight. Commands presented during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 01 fetch-and-reserve, 10 conditional write, 11 plain write |
| cmd_addr | input | ADDR_W | Byte address inside the target line |
| cmd_ready | output | 1 | Unit idle, command taken this cycle |
| mem_req | output | 1 | Memory access in flight |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_done | input | 1 | Memory access complete |
| snp_valid | input | 1 | Snooped write present |
| snp_addr | input | ADDR_W | Snooped write address |
| snp_self | input | 1 | Snooped write issued by this unit |
| evt_resv_lost | output | 1 | One-cycle reservation-lost event |
| stat_valid | output | 1 | Command completion pulse |
| stat_code | output | 2 | Last completion code: 0 fail, 1 cond ok, 2 fetched, 3 written |

## Verification
Every result falls at a fixed offset from its cause. The memory request and write enable appear in the cycle after acceptance. A failed conditional write shows its status in the cycle after acceptance. A completed access shows its status, and any fetch-time loss event, in the cycle after `mem_done`. A snoop kill shows its event in the cycle after the snoop. The bench drives each input just after a rising edge and samples just after the next edge, so each check lines up with exactly one register stage. A reference model updated once per cycle supplies the expected event, status and reservation, while random snoops, random waits and ignored commands during transfers vary the order of events.

// File: rtl/ra_pkg.sv
package ra_pkg;

    typedef enum logic [1:0] {
        OP_NONE       = 2'd0,
        OP_GET_RESV   = 2'd1,
        OP_PUT_COND   = 2'd2,
        OP_PUT_ALWAYS = 2'd3
    } ra_op_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FETCH     = 2'd1,
        ST_WR_COND   = 2'd2,
        ST_WR_UNCOND = 2'd3
    } ra_state_e;

    localparam logic [1:0] STAT_COND_FAIL = 2'd0;
    localparam logic [1:0] STAT_COND_OK   = 2'd1;
    localparam logic [1:0] STAT_GET_DONE  = 2'd2;
    localparam logic [1:0] STAT_PUT_DONE  = 2'd3;

endpackage

// File: rtl/ra_line_match.sv
module ra_line_match #(
    parameter int TAG_W = 25
) (
    input  logic             en,
    input  logic [TAG_W-1:0] a_tag,
    input  logic [TAG_W-1:0] b_tag,
    output logic             hit
);
    always_comb begin
        hit = en && (a_tag == b_tag);
    end
endmodule

// File: rtl/ra_snoop_filter.sv
module ra_snoop_filter #(
    parameter int TAG_W = 25
) (
    input  logic             snp_valid,
    input  logic             snp_self,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic             resv_valid,
    input  logic [TAG_W-1:0] resv_tag,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic [TAG_W-1:0] pend_tag,
    output logic             kill_resv,
    output logic             hit_cmd,
    output logic             hit_pend
);
    localparam int N_CMP = 3;

    logic             foreign;
    logic [TAG_W-1:0] cmp_tag [N_CMP];
    logic [N_CMP-1:0] cmp_en;
    logic [N_CMP-1:0] cmp_hit;

    always_comb begin
        foreign    = snp_valid && !snp_self;
        cmp_tag[0] = resv_tag;
        cmp_tag[1] = cmd_tag;
        cmp_tag[2] = pend_tag;
        cmp_en[0]  = foreign && resv_valid;
        cmp_en[1]  = foreign;
        cmp_en[2]  = foreign;
    end

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        ra_line_match #(.TAG_W(TAG_W)) u_match (
            .en    (cmp_en[g]),
            .a_tag (snp_tag),
            .b_tag (cmp_tag[g]),
            .hit   (cmp_hit[g])
        );
    end

    always_comb begin
        kill_resv = cmp_hit[0];
        hit_cmd   = cmp_hit[1];
        hit_pend  = cmp_hit[2];
    end
endmodule

// File: rtl/ra_resv_reg.sv
module ra_resv_reg #(
    parameter int TAG_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             kill,
    input  logic             fetch_lost,
    output logic             valid,
    output logic [TAG_W-1:0] tag,
    output logic             lost_evt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            tag      <= '0;
            lost_evt <= 1'b0;
        end else begin
            lost_evt <= (valid && kill) || fetch_lost;
            if (set) begin
                valid <= 1'b1;
                tag   <= set_tag;
            end else if (clr || kill) begin
                valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ra_ctrl_fsm.sv
module ra_ctrl_fsm
    import ra_pkg::*;
#(
    parameter int TAG_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic             mem_done,
    input  logic             resv_valid,
    input  logic [TAG_W-1:0] resv_tag,
    input  logic             kill_now,
    input  logic             snp_hit_cmd,
    input  logic             snp_hit_pend,
    output logic             cmd_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [TAG_W-1:0] pend_tag,
    output logic             resv_clr,
    output logic             resv_set,
    output logic             fetch_lost,
    output logic             stat_valid,
    output logic [1:0]       stat_code,
    output ra_state_e        state
);
    ra_state_e  state_q, state_d;
    logic [TAG_W-1:0] pend_tag_q;
    logic       pend_hit_q;
    logic       stat_valid_q;
    logic [1:0] stat_code_q;

    logic accept;
    logic cond_ok;
    logic done;
    logic taint;

    always_comb begin
        accept  = cmd_valid && (state_q == ST_IDLE) && (cmd_op != OP_NONE);
        cond_ok = resv_valid && (resv_tag == cmd_tag) && !kill_now;
        done    = mem_done && (state_q != ST_IDLE);
        taint   = pend_hit_q || snp_hit_pend;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (ra_op_e'(cmd_op))
                        OP_GET_RESV:   state_d = ST_FETCH;
                        OP_PUT_COND:   state_d = cond_ok ? ST_WR_COND : ST_IDLE;
                        OP_PUT_ALWAYS: state_d = ST_WR_UNCOND;
                        default:       state_d = ST_IDLE;
                    endcase
                end
            end
            ST_FETCH, ST_WR_COND, ST_WR_UNCOND: begin
                if (done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and per-command bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tag_q   <= '0;
            pend_hit_q   <= 1'b0;
            stat_valid_q <= 1'b0;
            stat_code_q  <= STAT_COND_FAIL;
        end else begin
            stat_valid_q <= 1'b0;
            if (accept) begin
                pend_tag_q <= cmd_tag;
                pend_hit_q <= snp_hit_cmd;
                if ((ra_op_e'(cmd_op) == OP_PUT_COND) && !cond_ok) begin
                    stat_valid_q <= 1'b1;
                    stat_code_q  <= STAT_COND_FAIL;
                end
            end else if (state_q == ST_FETCH) begin
                pend_hit_q <= taint;
            end
            if (done) begin
                stat_valid_q <= 1'b1;
                unique case (state_q)
                    ST_FETCH:     stat_code_q <= STAT_GET_DONE;
                    ST_WR_COND:   stat_code_q <= STAT_COND_OK;
                    ST_WR_UNCOND: stat_code_q <= STAT_PUT_DONE;
                    default:      stat_code_q <= stat_code_q;
                endcase
            end
        end
    end

    always_comb begin
        cmd_ready  = (state_q == ST_IDLE);
        mem_req    = (state_q != ST_IDLE);
        mem_we     = (state_q == ST_WR_COND) || (state_q == ST_WR_UNCOND);
        pend_tag   = pend_tag_q;
        resv_clr   = accept && ((ra_op_e'(cmd_op) == OP_GET_RESV) ||
                                (ra_op_e'(cmd_op) == OP_PUT_COND));
        resv_set   = (state_q == ST_FETCH) && done && !taint;
        fetch_lost = (state_q == ST_FETCH) && done && taint;
        stat_valid = stat_valid_q;
        stat_code  = stat_code_q;
        state      = state_q;
    end
endmodule

// File: rtl/ra_atomic_unit.sv
module ra_atomic_unit
    import ra_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_done,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_self,
    output logic              evt_resv_lost,
    output logic              stat_valid,
    output logic [1:0]        stat_code
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - OFS_W;

    logic [TAG_W-1:0] cmd_tag;
    logic [TAG_W-1:0] snp_tag;
    logic [TAG_W-1:0] pend_tag;
    logic [TAG_W-1:0] resv_tag;
    logic             resv_valid;
    logic             kill_now;
    logic             hit_cmd;
    logic             hit_pend;
    logic             resv_clr;
    logic             resv_set;
    logic             fetch_lost;
    ra_state_e        fsm_state;

    always_comb begin
        cmd_tag  = cmd_addr[ADDR_W-1:OFS_W];
        snp_tag  = snp_addr[ADDR_W-1:OFS_W];
        mem_addr = {pend_tag, {OFS_W{1'b0}}};
    end

    ra_snoop_filter #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_self   (snp_self),
        .snp_tag    (snp_tag),
        .resv_valid (resv_valid),
        .resv_tag   (resv_tag),
        .cmd_tag    (cmd_tag),
        .pend_tag   (pend_tag),
        .kill_resv  (kill_now),
        .hit_cmd    (hit_cmd),
        .hit_pend   (hit_pend)
    );

    ra_resv_reg #(.TAG_W(TAG_W)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (resv_clr),
        .set        (resv_set),
        .set_tag    (pend_tag),
        .kill       (kill_now),
        .fetch_lost (fetch_lost),
        .valid      (resv_valid),
        .tag        (resv_tag),
        .lost_evt   (evt_resv_lost)
    );

    ra_ctrl_fsm #(.TAG_W(TAG_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_tag      (cmd_tag),
        .mem_done     (mem_done),
        .resv_valid   (resv_valid),
        .resv_tag     (resv_tag),
        .kill_now     (kill_now),
        .snp_hit_cmd  (hit_cmd),
        .snp_hit_pend (hit_pend),
        .cmd_ready    (cmd_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .pend_tag     (pend_tag),
        .resv_clr     (resv_clr),
        .resv_set     (resv_set),
        .fetch_lost   (fetch_lost),
        .stat_valid   (stat_valid),
        .stat_code    (stat_code),
        .state        (fsm_state)
    );
endmodule

// File: rtl/ra_atomic_chk.sv
module ra_atomic_chk
    import ra_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              mem_req,
    input logic              mem_done,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_valid,
    input logic              snp_self,
    input logic              evt_resv_lost,
    input logic              stat_valid,
    input logic [1:0]        stat_code,
    input logic              resv_valid,
    input logic [ADDR_W-$clog2(LINE_BYTES)-1:0] resv_tag,
    input ra_state_e         fsm_state
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cmd_ready); // R11

    AST_DONE_GIVES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_done) |=> stat_valid); // R2

    AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_code == STAT_COND_FAIL) |-> !mem_req); // R5

    AST_COND_WRITE_HAD_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_WR_COND && $past(fsm_state) == ST_IDLE) |-> $past(resv_valid)); // R4

    AST_COND_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_WR_COND) |-> !resv_valid); // R6

    AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_self && resv_valid && snp_addr[ADDR_W-1:OFS_W] == resv_tag)
        |=> !resv_valid); // R8

    AST_EVT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_resv_lost |-> ($past(resv_valid) || $past(fsm_state) == ST_FETCH)); // R8

    AST_SELF_SNOOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_self && resv_valid && fsm_state != ST_IDLE) |=> resv_valid); // R9
endmodule

bind ra_atomic_unit ra_atomic_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_ready     (cmd_ready),
    .mem_req       (mem_req),
    .mem_done      (mem_done),
    .snp_addr      (snp_addr),
    .snp_valid     (snp_valid),
    .snp_self      (snp_self),
    .evt_resv_lost (evt_resv_lost),
    .stat_valid    (stat_valid),
    .stat_code     (stat_code),
    .resv_valid    (resv_valid),
    .resv_tag      (resv_tag),
    .fsm_state     (fsm_state)
);

// File: tb/tb_ra_atomic_unit.sv
`timescale 1ns/1ps
module tb_ra_atomic_unit;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_valid;
    logic [1:0]        cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_ready;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_done;
    logic              snp_valid;
    logic [ADDR_W-1:0] snp_addr;
    logic              snp_self;
    logic              evt_resv_lost;
    logic              stat_valid;
    logic [1:0]        stat_code;

    always #4 clk = ~clk;

    ra_atomic_unit dut (.*);

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;
    bit  rnd_snp  = 0;
    bit  m_valid  = 0;
    logic [24:0] m_tag = '0;

    localparam logic [1:0] GET = 2'd1, PUTC = 2'd2, PUTU = 2'd3;
    localparam logic [31:0] A = 32'h0000_1000, B = 32'h0004_2F00, C = 32'hFFFF_FF80;

    function automatic logic [24:0] line(input logic [31:0] a);
        return a[31:7];
    endfunction

    function automatic logic [31:0] pick_addr();
        logic [31:0] bases [4] = '{32'h0000_1000, 32'h0000_1080, 32'h0004_2F00, 32'hFFFF_FF80};
        return bases[$urandom % 4] + ($urandom % 128);
    endfunction

    function automatic logic exp_kill();
        return snp_valid && !snp_self && m_valid && (line(snp_addr) == m_tag);
    endfunction

    function automatic logic [1:0] done_code(input logic [1:0] op);
        return (op == GET) ? 2'd2 : (op == PUTC) ? 2'd1 : 2'd3;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic rand_snoop();
        if (rnd_snp && ($urandom % 5 == 0)) begin
            snp_valid = 1'b1;
            snp_addr  = pick_addr();
            snp_self  = ($urandom % 3 == 0);
        end else begin
            snp_valid = 1'b0;
        end
    endtask

    task automatic idle_snoop(input logic [31:0] addr, input bit self_w);
        logic ev;
        snp_valid = 1'b1; snp_addr = addr; snp_self = self_w;
        ev = exp_kill();
        if (ev) m_valid = 0;
        tick();
        snp_valid = 1'b0; snp_self = 1'b0;
        chk(self_w ? "R9" : "R8", "snoop event", evt_resv_lost, ev);
        chk("R9", "no status on snoop", stat_valid, 1'b0);
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [31:0] addr, input int lat, input bit force_taint);
        logic ev, ok, taint;
        chk("R11", "ready before command", cmd_ready, 1'b1);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
        rand_snoop();
        ev    = exp_kill();
        taint = snp_valid && !snp_self && (line(snp_addr) == line(addr));
        ok    = m_valid && !ev && (line(addr) == m_tag);
        if (op == GET || op == PUTC || ev) m_valid = 0;
        tick();
        cmd_valid = 1'b0; snp_valid = 1'b0;
        chk("R8", "event at accept", evt_resv_lost, ev);
        if (op == PUTC && !ok) begin
            chk("R5", "fail status pulse", stat_valid, 1'b1);
            chk("R5", "fail status code", stat_code, 2'd0);
            chk("R5", "no memory request", mem_req, 1'b0);
            return;
        end
        chk("R2", "no early status", stat_valid, 1'b0);
        chk(op == GET ? "R2" : (op == PUTC ? "R4" : "R7"), "mem_req", mem_req, 1'b1);
        chk(op == GET ? "R2" : (op == PUTC ? "R4" : "R7"), "mem_we", mem_we, op != GET);
        chk("R2", "line address", mem_addr, {addr[31:7], 7'b0});
        chk("R11", "busy", cmd_ready, 1'b0);
        for (int i = 0; i <= lat; i++) begin
            mem_done = (i == lat);
            rand_snoop();
            if (force_taint && i == 0) begin
                snp_valid = 1'b1; snp_self = 1'b0; snp_addr = addr ^ 32'h0000_0031;
            end
            cmd_valid = ($urandom % 2 == 0); cmd_op = GET; cmd_addr = pick_addr();
            ev = exp_kill();
            if (ev) m_valid = 0;
            if (snp_valid && !snp_self && line(snp_addr) == line(addr)) taint = 1;
            tick();
            cmd_valid = 1'b0; snp_valid = 1'b0; mem_done = 1'b0;
            if (i < lat) begin
                chk("R8", "event in transfer", evt_resv_lost, ev);
                chk("R11", "still busy", mem_req, 1'b1);
                chk("R11", "no status mid transfer", stat_valid, 1'b0);
            end else begin
                chk(op == GET ? "R10" : "R8", "event at completion", evt_resv_lost, ev || (op == GET && taint));
                chk("R2", "completion pulse", stat_valid, 1'b1);
                chk(op == GET ? "R2" : (op == PUTC ? "R4" : "R7"), "completion code", stat_code, done_code(op));
                chk("R11", "idle again", cmd_ready, 1'b1);
            end
        end
        if (op == GET && !taint) begin
            m_valid = 1;
            m_tag   = line(addr);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7345));
        rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_addr = 0;
        mem_done = 0; snp_valid = 0; snp_addr = 0; snp_self = 0;
        repeat (3) tick();
        chk("R1", "ready in reset", cmd_ready, 1'b1);
        chk("R1", "mem_req in reset", mem_req, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1", "ready", cmd_ready, 1'b1);
        chk("R1", "mem_req", mem_req, 1'b0);
        chk("R1", "event", evt_resv_lost, 1'b0);
        chk("R1", "stat_valid", stat_valid, 1'b0);
        chk("R1", "stat_code", stat_code, 2'd0);

        // R2 R4: reserve then conditional write succeeds
        run_cmd(GET, A, 2, 0);
        run_cmd(PUTC, A + 5, 1, 0);
        // R6: reservation used up, second attempt fails quietly
        run_cmd(PUTC, A, 0, 0);
        // R8: foreign write anywhere in the line kills it
        run_cmd(GET, A, 0, 0);
        idle_snoop(A + 32'h40, 0);
        run_cmd(PUTC, A, 0, 0);
        // R9: own write ignored, snoop without reservation silent
        run_cmd(GET, A, 1, 0);
        idle_snoop(A + 32'h10, 1);
        run_cmd(PUTC, A, 1, 0);
        idle_snoop(A, 0);
        // R3: newer fetch replaces older reservation
        run_cmd(GET, A, 0, 0);
        run_cmd(GET, B, 0, 0);
        run_cmd(PUTC, A, 0, 0);
        run_cmd(GET, B, 0, 0);
        run_cmd(PUTC, B, 0, 0);
        // R10: snoop during fetch prevents reservation
        run_cmd(GET, A, 2, 1);
        run_cmd(PUTC, A, 0, 0);
        // R7: plain write leaves reservation alone
        run_cmd(GET, A, 0, 0);
        run_cmd(PUTU, C, 2, 0);
        run_cmd(PUTC, A, 0, 0);
        // R8: neighbouring line is a different granule
        run_cmd(GET, A, 0, 0);
        idle_snoop(A + 32'h80, 0);
        run_cmd(PUTC, A, 0, 0);

        // random mix with snoops
        rnd_snp = 1;
        for (int k = 0; k < 400; k++) begin
            logic [1:0] op;
            op = 2'(1 + ($urandom % 3));
            if ($urandom % 2 == 0) op = ($urandom % 2) ? GET : PUTC;
            run_cmd(op, pick_addr(), int'($urandom % 4), 0);
            if ($urandom % 3 == 0) begin
                rand_snoop();
                idle_snoop(snp_valid ? snp_addr : pick_addr(), snp_valid ? snp_self : 1'b1);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule